// File: doc/BRIEF.md
# Line-Buffered AHB-Lite Front End for a Slow Wide Memory

This block is an AHB-Lite slave placed ahead of a slow memory array that is only ever read or written one 256-bit line at a time. A line holds eight 32-bit words. The slave captures each address phase. It keeps one line in a local buffer and steers the addressed 32-bit word between the bus and that buffer. While the array is busy, it holds HREADY low.

Once a line has been fetched, every further read that lands in it returns with no wait state. This gives single-cycle sequential bursts. Write beats are merged into the buffer with a per-byte dirty mask. The merged bytes go to the array in a single masked line write, either when the bus leaves the line or when the burst ends.

Illegal size, burst or alignment codes receive the standard two-cycle ERROR response. The array inside is a behavioural model with fixed read and write latencies, so the block can be used on its own. Both latencies must be at least 2.

Top module: `wide_line_ahb`

## Requirements
- R1: While reset is low and right after it is released, hready is 1 and hresp is 0. Write data gathered before reset is dropped, so no flush wait follows the reset.
- R2: A word read whose line is not held in the buffer sees exactly RD_LAT (default 4) cycles with hready low. It then returns the word selected by address bits [4:2] of the line (address bits [10:5] with the defaults).
- R3: Reads of a line already in the buffer complete with zero wait cycles, SEQ beats included, so a burst returns one word per clock.
- R4: A NONSEQ read to a different line pays the full RD_LAT wait cycles again.
- R5: Write beats into the buffered line complete with zero wait cycles and are merged. After they are committed, reads return the written words.
- R6: A write beat to a different line, while gathered bytes are still pending, waits exactly WR_LAT (default 6) cycles while those bytes are committed.
- R7: If gathered bytes are pending when the bus presents IDLE or NONSEQ (or deselects), the next data phase holds hready low for exactly WR_LAT cycles while the bytes are committed.
- R8: Byte (hsize 000) and halfword (hsize 001) writes change only their lanes. Byte lane n covers hwdata bits [8n+7:8n], with n = address bits [1:0]. A halfword uses lanes 0–1 when address bit 1 is 0 and lanes 2–3 when it is 1.
- R9: hburst codes 000, 001, 011, 101 and 111 are accepted with an OKAY response. Codes 010, 100 and 110 get one cycle of hresp=1 with hready=0, followed by one cycle of hresp=1 with hready=1.
- R10: An hsize of 011 or above, a misaligned halfword, or a misaligned word also gets the two-cycle ERROR, and the buffer and array are left unchanged.
- R11: IDLE (htrans 00) and BUSY (htrans 01) start no transfer. Their data phase completes with zero waits and OKAY, except for the flush described in R7.
- R12: A read that misses the buffer while gathered bytes are pending first commits them and then fetches, for WR_LAT + RD_LAT wait cycles in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock, rising edge |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Byte address of the address phase |
| htrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size code |
| hburst | input | 3 | Burst type code |
| hwdata | input | 32 | Write data, valid in the data phase |
| hrdata | output | 32 | Read data, valid when hready is high |
| hready | output | 1 | Data phase completes when high |
| hresp | output | 1 | 1 = ERROR response |

## Verification
Some properties are checked on every cycle:
- the two-cycle shape of every ERROR response;
- the rule that a read data phase only completes from a valid buffer line that matches;
- the rule that gathered bytes never span two lines;
- the rule that every completed write marks bytes dirty;
- the rule that BUSY costs nothing;
- a bound of RD_LAT+WR_LAT on any run of wait cycles.

Some behaviours can only be shown by the bench's scenarios: the exact wait counts for a miss, a flush and a flush followed by a fetch, the correct data after a commit, byte-lane merging, a rejected write leaving memory unchanged, and reset discarding pending bytes.

// File: rtl/wide_line_ahb.sv
module wide_line_ahb #(
  parameter int LINES  = 64,
  parameter int RD_LAT = 4,
  parameter int WR_LAT = 6
) (
  input  logic        hclk,
  input  logic        hresetn,
  input  logic        hsel,
  input  logic [31:0] haddr,
  input  logic [1:0]  htrans,
  input  logic        hwrite,
  input  logic [2:0]  hsize,
  input  logic [2:0]  hburst,
  input  logic [31:0] hwdata,
  output logic [31:0] hrdata,
  output logic        hready,
  output logic        hresp
);
  localparam int LW  = $clog2(LINES);
  localparam int MX  = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
  localparam int CW  = $clog2(MX + 1);

  typedef enum logic [1:0] {ST_RUN, ST_FLUSH, ST_FETCH, ST_ERR} st_t;
  st_t st;

  logic [255:0]  mem [LINES];
  logic [255:0]  lbuf;
  logic [31:0]   dirty;
  logic [LW-1:0] tag;
  logic          lok, fl_req;
  logic          dp_v, dp_w, dp_err;
  logic [LW+4:0] dp_a;
  logic [1:0]    dp_sz;
  logic [CW-1:0] cnt;
  logic          go_flush, go_fetch, go_err;
  logic [3:0]    lanes;

  wire [LW-1:0] dp_line  = dp_a[LW+4:5];
  wire [2:0]    dp_word  = dp_a[4:2];
  wire          same     = (tag == dp_line);
  wire          hit      = lok && same;
  wire          any_dirty = (dirty != '0);
  wire          run_st   = (st == ST_RUN);
  wire          flush_now = fl_req && any_dirty;
  wire          wr_flush = dp_v && dp_w && any_dirty && !same;
  wire          rd_miss  = dp_v && !dp_w && !hit;
  wire          fl_done  = (st == ST_FLUSH) && (cnt == CW'(WR_LAT - 1));
  wire          fe_done  = (st == ST_FETCH) && (cnt == CW'(RD_LAT - 1));
  wire          unused_hi = ^haddr[31:LW+5];

  always_comb begin
    hready = 1'b1; hresp = 1'b0;
    go_flush = 1'b0; go_fetch = 1'b0; go_err = 1'b0;
    case (st)
      ST_FLUSH, ST_FETCH: hready = 1'b0;
      ST_ERR:             hresp  = 1'b1;
      default: begin
        if (flush_now) begin
          hready = 1'b0; go_flush = 1'b1;
        end else if (dp_err) begin
          hready = 1'b0; hresp = 1'b1; go_err = 1'b1;
        end else if (wr_flush || (rd_miss && any_dirty)) begin
          hready = 1'b0; go_flush = 1'b1;
        end else if (rd_miss) begin
          hready = 1'b0; go_fetch = 1'b1;
        end
      end
    endcase
  end

  wire wr_go    = run_st && hready && dp_v && dp_w;
  wire acc      = hready && hsel && htrans[1];
  wire bad      = hsize[2] || (hsize == 3'b011) || (!hburst[0] && hburst != 3'b000)
                || (hsize == 3'b001 && haddr[0]) || (hsize == 3'b010 && haddr[1:0] != 2'b00);
  wire boundary = hready && !(hsel && htrans[0]);

  always_comb
    case (dp_sz)
      2'd0:    lanes = 4'b0001 << dp_a[1:0];
      2'd1:    lanes = dp_a[1] ? 4'b1100 : 4'b0011;
      default: lanes = 4'b1111;
    endcase

  wire [31:0] wmask = {28'b0, lanes} << {dp_word, 2'b00};

  assign hrdata = lbuf[{dp_word, 5'b0} +: 32];

  always_ff @(posedge hclk or negedge hresetn)
    if (!hresetn) begin
      st <= ST_RUN; cnt <= '0; dirty <= '0; tag <= '0; lok <= 1'b0; fl_req <= 1'b0;
      dp_v <= 1'b0; dp_w <= 1'b0; dp_err <= 1'b0; dp_a <= '0; dp_sz <= '0;
    end else begin
      if (hready) begin
        dp_v   <= acc && !bad;
        dp_err <= acc && bad;
        if (acc) begin
          dp_w <= hwrite; dp_a <= haddr[LW+4:0]; dp_sz <= hsize[1:0];
        end
      end
      if (boundary && (any_dirty || wr_go)) fl_req <= 1'b1;
      else if (fl_req && !any_dirty)        fl_req <= 1'b0;
      case (st)
        ST_RUN: begin
          cnt <= CW'(1);
          if (go_flush)      st <= ST_FLUSH;
          else if (go_fetch) st <= ST_FETCH;
          else if (go_err)   st <= ST_ERR;
          if (wr_go) begin
            if (same) dirty <= dirty | wmask;
            else begin dirty <= wmask; tag <= dp_line; lok <= 1'b0; end
          end
        end
        ST_FLUSH: begin
          cnt <= cnt + 1'b1;
          if (fl_done) begin dirty <= '0; st <= ST_RUN; end
        end
        ST_FETCH: begin
          cnt <= cnt + 1'b1;
          if (fe_done) begin tag <= dp_line; lok <= 1'b1; st <= ST_RUN; end
        end
        default: st <= ST_RUN;
      endcase
    end

  always_ff @(posedge hclk) begin
    if (fl_done)
      for (int b = 0; b < 32; b++)
        if (dirty[b]) mem[tag][b*8 +: 8] <= lbuf[b*8 +: 8];
    if (fe_done) lbuf <= mem[dp_line];
    else if (wr_go)
      for (int b = 0; b < 32; b++)
        if (wmask[b]) lbuf[b*8 +: 8] <= hwdata[(b%4)*8 +: 8];
  end
endmodule

// File: rtl/wide_line_ahb_chk.sv
module wide_line_ahb_chk #(
  parameter int LW     = 6,
  parameter int RD_LAT = 4,
  parameter int WR_LAT = 6
) (
  input logic          clk,
  input logic          rstn,
  input logic          hsel,
  input logic [1:0]    htrans,
  input logic          hready,
  input logic          hresp,
  input logic          in_run,
  input logic          dp_v,
  input logic          dp_w,
  input logic          lok,
  input logic          tag_hit,
  input logic [31:0]   dirty,
  input logic [LW-1:0] tag
);
  localparam int MAXW = RD_LAT + WR_LAT;
  localparam int KW   = $clog2(MAXW + 2);
  logic [KW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rstn)
    if (!rstn)                    low_cnt <= '0;
    else if (hready)              low_cnt <= '0;
    else if (low_cnt <= KW'(MAXW)) low_cnt <= low_cnt + 1'b1;

  AST_ERR_SECOND: assert property (@(posedge clk) disable iff (!rstn)
    hresp && !hready |=> hresp && hready); // R9
  AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rstn)
    hresp && hready |-> $past(hresp) && !$past(hready)); // R10
  AST_READ_FROM_LINE: assert property (@(posedge clk) disable iff (!rstn)
    in_run && hready && dp_v && !dp_w |-> lok && tag_hit); // R2
  AST_GATHER_ONE_LINE: assert property (@(posedge clk) disable iff (!rstn)
    (dirty != '0) && ($past(dirty) != '0) |-> tag == $past(tag)); // R5
  AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rstn)
    in_run && hready && dp_v && dp_w |=> dirty != '0); // R8
  AST_BUSY_FREE: assert property (@(posedge clk) disable iff (!rstn)
    hready && hsel && htrans == 2'b01 |=> hready && !hresp); // R11
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstn)
    low_cnt <= KW'(MAXW)); // R12
endmodule

bind wide_line_ahb wide_line_ahb_chk #(.LW(LW), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) u_chk (
  .clk(hclk), .rstn(hresetn), .hsel(hsel), .htrans(htrans), .hready(hready), .hresp(hresp),
  .in_run(run_st), .dp_v(dp_v), .dp_w(dp_w), .lok(lok), .tag_hit(same), .dirty(dirty), .tag(tag));

// File: tb/wide_line_ahb_bench.sv
module wide_line_ahb_bench;
  logic hclk = 1'b0, hresetn = 1'b0, hsel = 1'b0, hwrite = 1'b0;
  logic [31:0] haddr = '0, hwdata = '0;
  logic [1:0]  htrans = 2'b00;
  logic [2:0]  hsize = 3'b010, hburst = 3'b000;
  logic [31:0] hrdata;
  logic        hready, hresp;

  wide_line_ahb u_wide_line_ahb (.hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
    .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
    .hrdata(hrdata), .hready(hready), .hresp(hresp));

  always #4 hclk = ~hclk;

  int nchk = 0, nerr = 0, got_w;
  logic [31:0] got_rd;
  logic got_resp;

  typedef struct packed {
    logic [1:0] tr; logic wr; logic [2:0] sz; logic [2:0] bu;
    logic [31:0] ad; logic [31:0] wd;
    logic chk; logic [3:0] ew; logic es; logic crd; logic [31:0] er; logic [3:0] rq;
  } vec_t;

  localparam logic [1:0] ID = 2'b00, BZ = 2'b01, NS = 2'b10, SQ = 2'b11;
  localparam logic [2:0] SB = 3'b000, SH = 3'b001, SW = 3'b010;
  localparam logic [2:0] SGL = 3'b000, INC = 3'b001, I4 = 3'b011, I8 = 3'b101, I16 = 3'b111;
  localparam int NV = 48;

  localparam vec_t VEC [NV] = '{
    '{NS,1,SW,I8, 32'h000,32'h0,        0,0,0,0,32'h0,5},
    '{SQ,1,SW,I8, 32'h004,32'hC0DE0000, 1,0,0,0,32'h0,5},   // R5
    '{SQ,1,SW,I8, 32'h008,32'hC0DE0001, 1,0,0,0,32'h0,5},
    '{SQ,1,SW,I8, 32'h00C,32'hC0DE0002, 1,0,0,0,32'h0,5},
    '{SQ,1,SW,I8, 32'h010,32'hC0DE0003, 1,0,0,0,32'h0,5},
    '{SQ,1,SW,I8, 32'h014,32'hC0DE0004, 1,0,0,0,32'h0,5},
    '{SQ,1,SW,I8, 32'h018,32'hC0DE0005, 1,0,0,0,32'h0,5},
    '{SQ,1,SW,I8, 32'h01C,32'hC0DE0006, 1,0,0,0,32'h0,5},
    '{ID,0,SW,SGL,32'h0,  32'hC0DE0007, 1,0,0,0,32'h0,5},
    '{ID,0,SW,SGL,32'h0,  32'h0,        1,6,0,0,32'h0,7},   // R7 idle flush
    '{NS,0,SW,SGL,32'h008,32'h0,        1,0,0,0,32'h0,11},  // R11
    '{ID,0,SW,SGL,32'h0,  32'h0,        1,4,0,1,32'hC0DE0002,2}, // R2
    '{NS,0,SW,I4, 32'h010,32'h0,        0,0,0,0,32'h0,3},
    '{SQ,0,SW,I4, 32'h014,32'h0,        1,0,0,1,32'hC0DE0004,3}, // R3
    '{BZ,0,SW,I4, 32'h018,32'h0,        1,0,0,1,32'hC0DE0005,3},
    '{SQ,0,SW,I4, 32'h018,32'h0,        1,0,0,0,32'h0,11},  // R11 busy
    '{SQ,0,SW,I4, 32'h01C,32'h0,        1,0,0,1,32'hC0DE0006,3},
    '{NS,0,SW,SGL,32'h120,32'h0,        1,0,0,1,32'hC0DE0007,3},
    '{ID,0,SW,SGL,32'h0,  32'h0,        1,4,0,0,32'h0,4},   // R4
    '{NS,0,SW,SGL,32'h004,32'h0,        0,0,0,0,32'h0,4},
    '{ID,0,SW,SGL,32'h0,  32'h0,        1,4,0,1,32'hC0DE0001,4},
    '{NS,1,SB,SGL,32'h009,32'h0,        1,0,0,0,32'h0,8},
    '{NS,1,SH,SGL,32'h00E,32'h11223344, 1,0,0,0,32'h0,8},   // R8
    '{ID,0,SW,SGL,32'h0,  32'h55667788, 1,6,0,0,32'h0,7},
    '{NS,0,SW,SGL,32'h008,32'h0,        1,6,0,0,32'h0,7},
    '{NS,0,SW,SGL,32'h00C,32'h0,        1,0,0,1,32'hC0DE3302,8},
    '{ID,0,SW,SGL,32'h0,  32'h0,        1,0,0,1,32'h55660003,8},
    '{NS,0,SW,3'b010,32'h000,32'h0,     0,0,0,0,32'h0,9},
    '{ID,0,SW,SGL,32'h0,  32'h0,        1,1,1,0,32'h0,9},   // R9
    '{NS,0,3'b011,SGL,32'h000,32'h0,    0,0,0,0,32'h0,10},
    '{ID,0,SW,SGL,32'h0,  32'h0,        1,1,1,0,32'h0,10},  // R10
    '{NS,1,SW,SGL,32'h002,32'h0,        0,0,0,0,32'h0,10},
    '{ID,0,SW,SGL,32'h0,  32'hDEADBEEF, 1,1,1,0,32'h0,10},
    '{NS,0,SW,SGL,32'h000,32'h0,        0,0,0,0,32'h0,10},
    '{ID,0,SW,SGL,32'h0,  32'h0,        1,0,0,1,32'hC0DE0000,10},
    '{NS,1,SW,INC,32'h05C,32'h0,        0,0,0,0,32'h0,6},
    '{SQ,1,SW,INC,32'h060,32'hE0000000, 1,0,0,0,32'h0,5},
    '{SQ,1,SW,INC,32'h064,32'hE0000001, 1,6,0,0,32'h0,6},   // R6
    '{ID,0,SW,SGL,32'h0,  32'hE0000002, 1,0,0,0,32'h0,6},
    '{ID,0,SW,SGL,32'h0,  32'h0,        1,6,0,0,32'h0,7},
    '{NS,0,SW,SGL,32'h05C,32'h0,        0,0,0,0,32'h0,4},
    '{NS,0,SW,SGL,32'h060,32'h0,        1,4,0,1,32'hE0000000,4},
    '{ID,0,SW,SGL,32'h0,  32'h0,        1,4,0,1,32'hE0000001,4},
    '{NS,1,SW,SGL,32'h100,32'h0,        0,0,0,0,32'h0,12},
    '{NS,0,SW,SGL,32'h05C,32'hF00D0000, 1,0,0,0,32'h0,12},
    '{ID,0,SW,SGL,32'h0,  32'h0,        1,10,0,1,32'hE0000000,12}, // R12
    '{NS,0,SW,I16,32'h100,32'h0,        0,0,0,0,32'h0,9},
    '{ID,0,SW,SGL,32'h0,  32'h0,        1,4,0,1,32'hF00D0000,9}
  };

  task automatic check(input int rq, input string what, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic step(input logic [1:0] tr, input logic wr, input logic [2:0] sz,
                      input logic [2:0] bu, input logic [31:0] ad, input logic [31:0] wd);
    @(negedge hclk);
    hsel = 1'b1; htrans = tr; hwrite = wr; hsize = sz; hburst = bu; haddr = ad; hwdata = wd;
    got_w = 0;
    while (!hready) begin got_w++; @(negedge hclk); end
    got_rd = hrdata; got_resp = hresp;
  endtask

  initial begin
    #1600000;
    nerr++; nchk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge hclk);
    check(1, "reset hready", {31'b0, hready}, 32'd1);       // R1
    check(1, "reset hresp",  {31'b0, hresp},  32'd0);       // R1
    hresetn = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].tr, VEC[i].wr, VEC[i].sz, VEC[i].bu, VEC[i].ad, VEC[i].wd);
      if (VEC[i].chk) begin
        check(int'(VEC[i].rq), $sformatf("step %0d waits", i), got_w, {28'b0, VEC[i].ew});
        check(int'(VEC[i].rq), $sformatf("step %0d resp", i), {31'b0, got_resp}, {31'b0, VEC[i].es});
        if (VEC[i].crd)
          check(int'(VEC[i].rq), $sformatf("step %0d rdata", i), got_rd, VEC[i].er);
      end
    end
    // R1: reset while gathered bytes are pending drops them
    step(NS, 1, SW, SGL, 32'h1A0, 32'h0);
    step(ID, 0, SW, SGL, 32'h0, 32'h12345678);
    @(negedge hclk);
    hresetn = 1'b0;
    @(negedge hclk);
    check(1, "hready in reset", {31'b0, hready}, 32'd1);
    hresetn = 1'b1;
    @(negedge hclk);
    check(1, "hready after reset", {31'b0, hready}, 32'd1);
    check(1, "hresp after reset", {31'b0, hresp}, 32'd0);
    step(ID, 0, SW, SGL, 32'h0, 32'h0);
    step(ID, 0, SW, SGL, 32'h0, 32'h0);
    check(1, "no flush after reset", got_w, 32'd0);
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule